// File: doc/BRIEF.md
# Windowed Address Stepper

This block produces a sequence of one-dimensional addresses inside a movable window. A base register and a limit register bound the window. An address register starts at the base and moves by a signed step each time a consumer accepts an address. A scan stops for one of three reasons: the step budget is used up, the address passes the limit in the direction of travel, or an escape request arrives. Several such units, each driving one axis, can be combined by surrounding logic into a multi-dimensional scan.

Addresses leave through a valid/ready stream. `addr_valid` is high for the whole of a scan. One address is transferred on each clock edge where `addr_valid` and `addr_ready` are both high. While `addr_ready` is low, the address stays the same and no step or budget is spent. The consumer may hold `addr_ready` low for as long as it needs. Outside a scan, `addr_ready` has no effect.

A scan can begin in two ways. `init` captures a full configuration. `rescan` starts a new scan over a window that has moved: the base and the limit are each shifted by their own stored signed slide amount, and the configuration is not loaded again.

Top module: `addr_stepper_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it, `addr` is 0 and `addr_valid`, `end_exec` and `escape_flag` are all low.
- R2: A clock edge with `init` high captures base, limit, step, step budget and both slide amounts. In the next cycle `addr` equals the captured base, `addr_valid` is high, and `escape_flag` and `end_exec` are low.
- R3: A transfer that does not end the scan moves `addr` by the signed step, using two's-complement arithmetic modulo 2^AW. The new value is visible in the next cycle.
- R4: While `addr_valid` is high and `addr_ready` is low, with no `init`, `rescan` or `escape_req`, `addr` and `addr_valid` keep their values.
- R5: With a non-zero step budget N, the N-th transfer ends the scan. A budget of 0 sets no count bound.
- R6: A transfer of address A ends the scan when A >= limit (unsigned) and the step's sign bit is 0, or when A <= limit and the sign bit is 1. The limit test applies to the address being transferred, so A is the last address of the scan.
- R7: When a scan ends, `end_exec` is high for exactly one cycle, the cycle after the ending edge. In that cycle `addr_valid` is low and `addr` still shows the last address transferred. If the count bound and the limit bound are both met on the same transfer, there is still only one pulse.
- R8: After the end of a scan, `addr` and `addr_valid` do not change and `end_exec` stays low until the next `init` or `rescan`, whatever `addr_ready` does.
- R9: An `escape_req` sampled while `addr_valid` is high ends the scan on that edge. In the next cycle `addr_valid` is low, `end_exec` pulses and `escape_flag` is high. `escape_flag` stays high until the next start. An `escape_req` sampled while `addr_valid` is low has no effect.
- R10: A `rescan` adds the stored base slide to the base and the stored limit slide to the limit, starts a scan at the new base, and uses the stored step and step budget. `escape_flag` is cleared.
- R11: If `init` and `rescan` are high on the same edge, `init` takes effect and the slides are not applied. A start on the same edge as an ending condition gives no `end_exec` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_base | input | AW | Start of the window, captured on `init` |
| cfg_limit | input | AW | End of the window, captured on `init` |
| cfg_step | input | AW | Signed address increment per transfer |
| cfg_max_steps | input | CW | Step budget, 0 means no count bound |
| cfg_base_slide | input | AW | Signed amount the base moves on `rescan` |
| cfg_limit_slide | input | AW | Signed amount the limit moves on `rescan` |
| init | input | 1 | Capture the configuration and start a scan |
| rescan | input | 1 | Move the window and start a new scan |
| escape_req | input | 1 | Request to end the current scan early |
| addr_ready | input | 1 | Consumer accepts the current address |
| addr_valid | output | 1 | An address is on offer (scan active) |
| addr | output | AW | Current address |
| end_exec | output | 1 | One-cycle pulse after a scan ends |
| escape_flag | output | 1 | The last scan ended by escape |

## Verification
Most errors in internal state first show up as a wrong `addr` one cycle after the transfer that used the bad value. A step register that is wrong gives a wrong difference between consecutive addresses. A base or slide that is wrong gives a wrong first address after `init` or `rescan`. A budget counter or limit register that is wrong is harder to see: no output changes until the scan ends one transfer too early or too late, and the error then appears as an `end_exec` pulse in the wrong cycle and a wrong final `addr`. For this reason the stimulus includes short scans and scans that end exactly at the boundary, so these faults appear within a few cycles.

// File: rtl/addr_step_pkg.sv
package addr_step_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } scan_state_e;
endpackage

// File: rtl/slide_reg.sv
module slide_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         bump,
  input  logic [W-1:0] delta,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (ld)   q <= ld_val;
    else if (bump) q <= q + delta;
  end
endmodule

// File: rtl/step_budget.sv
module step_budget #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          last
);
  localparam logic [CW-1:0] ONE = CW'(1);
  logic [CW-1:0] left_q;
  logic          bounded_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q    <= '0;
      bounded_q <= 1'b0;
    end else if (load) begin
      left_q    <= load_val;
      bounded_q <= (load_val != '0);
    end else if (dec && bounded_q && left_q != '0) begin
      left_q <= left_q - ONE;
    end
  end

  assign last = bounded_q && (left_q == ONE);
endmodule

// File: rtl/window_edge_detect.sv
module window_edge_detect #(
  parameter int W = 16
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] bound,
  input  logic         going_down,
  output logic         hit
);
  always_comb begin
    if (going_down) hit = (cur <= bound);
    else            hit = (cur >= bound);
  end
endmodule

// File: rtl/addr_stepper_unit.sv
module addr_stepper_unit
  import addr_step_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cfg_base,
  input  logic [AW-1:0] cfg_limit,
  input  logic [AW-1:0] cfg_step,
  input  logic [CW-1:0] cfg_max_steps,
  input  logic [AW-1:0] cfg_base_slide,
  input  logic [AW-1:0] cfg_limit_slide,
  input  logic          init,
  input  logic          rescan,
  input  logic          escape_req,
  input  logic          addr_ready,
  output logic          addr_valid,
  output logic [AW-1:0] addr,
  output logic          end_exec,
  output logic          escape_flag
);
  localparam int SIGN = AW - 1;

  scan_state_e   state_q;
  logic [AW-1:0] step_q, bslide_q, lslide_q;
  logic [CW-1:0] budget_q;
  logic [AW-1:0] base_q, limit_q, addr_q, base_nx;
  logic          start, xfer, cnt_last, lim_hit, term;
  logic          end_q, esc_q;

  assign start   = init | rescan;
  assign xfer    = (state_q == ST_RUN) && addr_ready;
  assign term    = (state_q == ST_RUN) && (escape_req || (xfer && (cnt_last || lim_hit)));
  assign base_nx = base_q + bslide_q;

  // stored configuration
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q   <= '0;
      bslide_q <= '0;
      lslide_q <= '0;
      budget_q <= '0;
    end else if (init) begin
      step_q   <= cfg_step;
      bslide_q <= cfg_base_slide;
      lslide_q <= cfg_limit_slide;
      budget_q <= cfg_max_steps;
    end
  end

  // three registers of the same structure: base, address, limit
  slide_reg #(.W(AW)) u_base (
    .clk(clk), .rst_n(rst_n),
    .ld(init), .ld_val(cfg_base),
    .bump(rescan && !init), .delta(bslide_q),
    .q(base_q)
  );

  slide_reg #(.W(AW)) u_addr (
    .clk(clk), .rst_n(rst_n),
    .ld(start), .ld_val(init ? cfg_base : base_nx),
    .bump(xfer && !term && !start), .delta(step_q),
    .q(addr_q)
  );

  slide_reg #(.W(AW)) u_limit (
    .clk(clk), .rst_n(rst_n),
    .ld(init), .ld_val(cfg_limit),
    .bump(rescan && !init), .delta(lslide_q),
    .q(limit_q)
  );

  step_budget #(.CW(CW)) u_budget (
    .clk(clk), .rst_n(rst_n),
    .load(start), .load_val(init ? cfg_max_steps : budget_q),
    .dec(xfer && !start),
    .last(cnt_last)
  );

  window_edge_detect #(.W(AW)) u_edge (
    .cur(addr_q), .bound(limit_q),
    .going_down(step_q[SIGN]),
    .hit(lim_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      end_q   <= 1'b0;
      esc_q   <= 1'b0;
    end else begin
      end_q <= term && !start;
      if (start)     state_q <= ST_RUN;
      else if (term) state_q <= ST_IDLE;
      if (start)                              esc_q <= 1'b0;
      else if (state_q == ST_RUN && escape_req) esc_q <= 1'b1;
    end
  end

  assign addr_valid  = (state_q == ST_RUN);
  assign addr        = addr_q;
  assign end_exec    = end_q;
  assign escape_flag = esc_q;
endmodule

// File: rtl/addr_stepper_chk.sv
module addr_stepper_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] cfg_base,
  input logic          init,
  input logic          rescan,
  input logic          escape_req,
  input logic          addr_ready,
  input logic          addr_valid,
  input logic [AW-1:0] addr,
  input logic          end_exec,
  input logic          escape_flag
);
  a_r2_init_loads: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (addr_valid && addr == $past(cfg_base) && !escape_flag && !end_exec));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_ready && !init && !rescan && !escape_req) |=> (addr_valid && $stable(addr)));

  a_r7_idle_on_end: assert property (@(posedge clk) disable iff (!rst_n)
    end_exec |-> !addr_valid);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    end_exec |=> !end_exec);

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_valid && !init && !rescan) |=> (!addr_valid && $stable(addr) && !end_exec));

  a_r9_escape_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && escape_req && !init && !rescan) |=> (!addr_valid && end_exec && escape_flag));

  a_r9_flag_with_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(escape_flag) |-> end_exec);
endmodule

bind addr_stepper_unit addr_stepper_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base),
  .init(init), .rescan(rescan), .escape_req(escape_req), .addr_ready(addr_ready),
  .addr_valid(addr_valid), .addr(addr), .end_exec(end_exec), .escape_flag(escape_flag)
);

// File: tb/test_addr_stepper_unit.sv
module test_addr_stepper_unit;
  localparam int AW = 16;
  localparam int CW = 8;
  localparam time HALF = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] cfg_base = '0, cfg_limit = '0, cfg_step = '0;
  logic [CW-1:0] cfg_max_steps = '0;
  logic [AW-1:0] cfg_base_slide = '0, cfg_limit_slide = '0;
  logic          init = 1'b0, rescan = 1'b0, escape_req = 1'b0, addr_ready = 1'b0;
  logic          addr_valid, end_exec, escape_flag;
  logic [AW-1:0] addr;

  int checks = 0;
  int failures = 0;

  // reference state derived from the requirements
  logic [AW-1:0] m_base, m_limit, m_step, m_bs, m_ls, m_addr;
  logic [CW-1:0] m_max, m_cnt;
  logic          m_bounded, m_valid, m_end, m_esc;

  always #HALF clk = ~clk;

  addr_stepper_unit #(.AW(AW), .CW(CW)) i_addr_stepper_unit (
    .clk(clk), .rst_n(rst_n),
    .cfg_base(cfg_base), .cfg_limit(cfg_limit), .cfg_step(cfg_step),
    .cfg_max_steps(cfg_max_steps), .cfg_base_slide(cfg_base_slide),
    .cfg_limit_slide(cfg_limit_slide),
    .init(init), .rescan(rescan), .escape_req(escape_req), .addr_ready(addr_ready),
    .addr_valid(addr_valid), .addr(addr), .end_exec(end_exec), .escape_flag(escape_flag)
  );

  function automatic logic limit_met(logic [AW-1:0] a, logic [AW-1:0] l, logic [AW-1:0] s);
    if (s[AW-1]) return a <= l;
    return a >= l;
  endfunction

  task automatic expect_eq(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    checks++;
    if (addr_valid !== m_valid || end_exec !== m_end || escape_flag !== m_esc ||
        addr !== m_addr) begin
      failures++;
      $display("FAIL %s actual addr=%0d v=%0b e=%0b x=%0b expected addr=%0d v=%0b e=%0b x=%0b",
               tag, addr, addr_valid, end_exec, escape_flag, m_addr, m_valid, m_end, m_esc);
    end
  endtask

  task automatic set_cfg(input int b, input int l, input int s, input int mx,
                         input int bs, input int ls);
    cfg_base = AW'(b); cfg_limit = AW'(l); cfg_step = AW'(s);
    cfg_max_steps = CW'(mx); cfg_base_slide = AW'(bs); cfg_limit_slide = AW'(ls);
  endtask

  task automatic tick(input logic i_init, input logic i_rescan, input logic i_esc,
                      input logic i_rdy, input string tag);
    logic start, hs, last, term;
    @(negedge clk);
    init = i_init; rescan = i_rescan; escape_req = i_esc; addr_ready = i_rdy;
    start = i_init | i_rescan;
    hs    = m_valid & i_rdy;
    last  = m_bounded && (m_cnt == CW'(1));
    term  = m_valid & (i_esc | (hs & (last | limit_met(m_addr, m_limit, m_step))));
    m_end = term & !start;
    if (start) m_esc = 1'b0;
    else if (m_valid & i_esc) m_esc = 1'b1;
    if (i_init) begin
      m_base = cfg_base; m_limit = cfg_limit; m_step = cfg_step;
      m_bs = cfg_base_slide; m_ls = cfg_limit_slide; m_max = cfg_max_steps;
      m_addr = cfg_base; m_cnt = m_max; m_bounded = (m_max != 0); m_valid = 1'b1;
    end else if (i_rescan) begin
      m_base = m_base + m_bs; m_limit = m_limit + m_ls;
      m_addr = m_base; m_cnt = m_max; m_bounded = (m_max != 0); m_valid = 1'b1;
    end else if (term) begin
      m_valid = 1'b0;
    end else if (hs) begin
      m_addr = m_addr + m_step;
      if (m_bounded) m_cnt = m_cnt - CW'(1);
    end
    @(posedge clk);
    #2ns;
    compare_all(tag);
  endtask

  initial begin : watchdog
    #(HALF * 2 * 200000);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int n;
    m_base = '0; m_limit = '0; m_step = '0; m_bs = '0; m_ls = '0; m_addr = '0;
    m_max = '0; m_cnt = '0; m_bounded = 1'b0; m_valid = 1'b0; m_end = 1'b0; m_esc = 1'b0;
    void'($urandom(32'd7321));

    // R1 reset state
    repeat (3) @(posedge clk);
    #2ns;
    compare_all("R1 during reset");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2ns;
    compare_all("R1 after reset");

    // R8: ready while idle has no effect
    tick(0, 0, 0, 1, "R8 idle ready");
    // R9: escape while idle is ignored
    tick(0, 0, 1, 1, "R9 idle escape");

    // R2, R3, R6: upward scan ends after passing limit 110
    set_cfg(100, 110, 3, 0, 0, 0);
    tick(1, 0, 0, 0, "R2 init");
    expect_eq("R2 first address", addr, 100);
    for (int i = 0; i < 5; i++) tick(0, 0, 0, 1, "R3 R6 up scan");
    expect_eq("R6 last address", addr, 112);
    expect_eq("R7 end pulse", end_exec, 1);
    tick(0, 0, 0, 1, "R7 pulse drops");
    expect_eq("R8 hold after end", addr, 112);

    // R6 downward step
    set_cfg(50, 40, -5, 0, 0, 0);
    tick(1, 0, 0, 1, "R2 init down");
    for (int i = 0; i < 3; i++) tick(0, 0, 0, 1, "R6 down scan");
    expect_eq("R6 down end", end_exec, 1);
    expect_eq("R6 down last", addr, 40);

    // R5 count bound with R4 back-pressure
    set_cfg(1000, 60000, 7, 3, 0, 0);
    tick(1, 0, 0, 0, "R5 init");
    n = 0;
    for (int i = 0; i < 12; i++) begin
      tick(0, 0, 0, (i % 3) != 0, "R4 R5 count scan");
      if (end_exec) n = i;
    end
    expect_eq("R5 final address", addr, 1014);
    expect_eq("R5 ended", addr_valid, 0);

    // R7 both bounds on same transfer give one pulse
    set_cfg(0, 4, 2, 3, 0, 0);
    tick(1, 0, 0, 1, "R7 init");
    tick(0, 0, 0, 1, "R7 both");
    tick(0, 0, 0, 1, "R7 both");
    tick(0, 0, 0, 1, "R7 both end");
    expect_eq("R7 single pulse", end_exec, 1);
    tick(0, 0, 0, 1, "R7 no second pulse");
    expect_eq("R7 no second pulse", end_exec, 0);

    // R9 escape mid scan, with ready
    set_cfg(200, 900, 1, 0, 0, 0);
    tick(1, 0, 0, 1, "R9 init");
    tick(0, 0, 0, 1, "R9 run");
    tick(0, 0, 1, 1, "R9 escape");
    expect_eq("R9 escape flag", escape_flag, 1);
    tick(0, 0, 0, 1, "R9 flag held");
    expect_eq("R9 flag held", escape_flag, 1);

    // R10 rescan slides the window
    set_cfg(10, 20, 4, 0, 16, 16);
    tick(1, 0, 0, 1, "R10 init");
    for (int i = 0; i < 3; i++) tick(0, 0, 0, 1, "R10 first window");
    set_cfg(500, 600, 1, 1, 1, 1);
    tick(0, 1, 0, 0, "R10 rescan");
    expect_eq("R10 new base", addr, 26);
    for (int i = 0; i < 3; i++) tick(0, 0, 0, 1, "R10 second window");
    expect_eq("R10 new limit end", addr, 38);

    // R11 init beats rescan
    set_cfg(300, 400, 2, 0, 50, 50);
    tick(1, 1, 0, 1, "R11 init wins");
    expect_eq("R11 base unslid", addr, 300);

    // random scans
    for (int s = 0; s < 80; s++) begin
      set_cfg($urandom_range(0, 4000), $urandom_range(0, 8000),
              int'($urandom_range(0, 16)) - 8, $urandom_range(0, 12),
              int'($urandom_range(0, 64)) - 32, int'($urandom_range(0, 64)) - 32);
      tick(1, 0, 0, $urandom_range(0, 1), "R3 random init");
      for (int c = 0; c < 40; c++) begin
        tick(0, ($urandom_range(0, 29) == 0), ($urandom_range(0, 39) == 0),
             ($urandom_range(0, 3) != 0), "R5 R6 R10 random");
      end
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule